// File: doc/BRIEF.md
# Receive Interrupt Coalescer with Tag Handshake

This block sits beside a receive channel's DMA engine and decides when the host gets an interrupt for the messages that have landed in its receive area. Rather than interrupting once per message, it groups arrivals into a window. The window closes when enough messages have gathered, or when a programmed number of 100 µs ticks has passed since the window's first event. When a window closes, the block builds a 32-bit status word and pulses a write strobe, so the DMA engine can store that word at the head of the host area. It then raises an interrupt request.

The interrupt line may be shared between channels. The status word therefore carries a 4-bit tag, and the host compares it with the tag it expects. After the host has handled the messages, it acknowledges by writing the next tag, which is the current tag plus one modulo 16. That write re-arms the block, and the next status word carries the new tag. Between a status write and its acknowledge, the word is held fixed. Arrivals in that gap are not lost: they are counted toward the following window. Control set and clear writes turn the interrupt enable and a DMA reset on and off. A limit register holds the count limit and the time limit.

Top module: `rxc_irq_coalescer`

## Requirements
- R1: After reset, irq and stat_wr are 0, stat_word is 0, the DMA reset is set, the interrupt enable is clear, the count limit is 16, the time limit is 10, and the block is not armed.
- R2: The status word holds the tag in bits [3:0], the pending message count in bits [10:4] and the link flag in bit 16. All other bits are 0.
- R3: When armed and enabled, the block reacts once the pending count reaches a non-zero count limit. In the next cycle, stat_wr pulses for exactly one cycle, irq rises and stat_word carries that count.
- R4: The timer starts at zero at the first event of a window and counts tick pulses. When it reaches the time limit with fewer messages than the count limit, the window closes with the count gathered so far.
- R5: A link strobe alone opens a window. When the time limit expires, the status word shows bit 16 set and a count of 0.
- R6: After a status write, irq stays high and stat_word stays unchanged until an acknowledge. Messages and link events that arrive in the meantime, including in the closing cycle, belong to the next window.
- R7: An acknowledge loads ack_tag as the current tag, clears irq and arms the block. Nothing fires before the first acknowledge after reset, and the next status word carries the acknowledged tag.
- R8: A write to the limit register takes the count limit from bits [7:0] and the time limit from bits [15:8].
- R9: A control write sets (ctl_set_we) or clears (ctl_clr_we) the interrupt enable at bit 18 and the DMA reset at bit 17. When a bit is set and cleared in the same cycle, the clear wins.
- R10: While the DMA reset is set, the pending count, the link flag and the timer are held at zero, incoming strobes are ignored, and no status write occurs.
- R11: The pending count saturates at 127.
- R12: While the interrupt enable is clear, arrivals still accumulate but nothing fires. Setting the enable lets a limit that has already been met fire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| msg_stb | input | 1 | One message written to the receive area |
| lnk_stb | input | 1 | Transmit link event |
| tick | input | 1 | 100 µs time base pulse |
| ctl_set_we | input | 1 | Set the control bits that are 1 in ctl_wdata |
| ctl_clr_we | input | 1 | Clear the control bits that are 1 in ctl_wdata |
| ctl_wdata | input | 32 | Control write data (bit 18 enable, bit 17 DMA reset) |
| lim_we | input | 1 | Limit register write |
| lim_wdata | input | 16 | Time limit in [15:8], count limit in [7:0] |
| ack_we | input | 1 | Host acknowledge write |
| ack_tag | input | 4 | Tag for the next window |
| stat_word | output | 32 | Status word for the head of the receive area |
| stat_wr | output | 1 | One-cycle strobe to store stat_word |
| irq | output | 1 | Interrupt request, held until acknowledge |

## Verification
The assertions assume that the host acknowledges only while irq is high, so an acknowledge never lands in the cycle a window closes. The bench's random host honours this: it waits a random delay after seeing irq before it writes the incremented tag, and writes nothing otherwise. The assertions also assume that tick is a single-cycle pulse. The random stimulus draws it as an independent one-cycle strobe, and the directed sections pulse it one cycle at a time.

// File: rtl/rxc_pkg.sv
package rxc_pkg;
    // status word field positions (decoded by the host)
    localparam int TAG_LSB  = 0;
    localparam int CNT_LSB  = 4;
    localparam int LNK_BIT  = 16;
    // control word bit positions
    localparam int DRST_BIT = 17;
    localparam int IEN_BIT  = 18;
    localparam int CTL_W    = 32;
    localparam int STAT_W   = 32;
endpackage

// File: rtl/rxc_cfg.sv
module rxc_cfg
    import rxc_pkg::*;
#(
    parameter int CLIM_W   = 8,
    parameter int TIME_W   = 8,
    parameter int DEF_CLIM = 16,
    parameter int DEF_TIME = 10,
    localparam int LIM_W   = CLIM_W + TIME_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_we,
    input  logic              clr_we,
    input  logic [CTL_W-1:0]  wdata,
    input  logic              lim_we,
    input  logic [LIM_W-1:0]  lim_wdata,
    output logic              ien,
    output logic              drst,
    output logic [CLIM_W-1:0] clim,
    output logic [TIME_W-1:0] tlim
);
    typedef struct packed {
        logic              ien;
        logic              drst;
        logic [CLIM_W-1:0] clim;
        logic [TIME_W-1:0] tlim;
    } cfg_t;

    cfg_t s_d, s_q;

    logic unused_ctl_bits;
    assign unused_ctl_bits = ^{wdata[CTL_W-1:IEN_BIT+1], wdata[DRST_BIT-1:0]};

    always_comb begin
        s_d = s_q;
        if (set_we) begin
            if (wdata[IEN_BIT])  s_d.ien  = 1'b1;
            if (wdata[DRST_BIT]) s_d.drst = 1'b1;
        end
        if (clr_we) begin
            if (wdata[IEN_BIT])  s_d.ien  = 1'b0;
            if (wdata[DRST_BIT]) s_d.drst = 1'b0;
        end
        if (lim_we) begin
            s_d.clim = lim_wdata[CLIM_W-1:0];
            s_d.tlim = lim_wdata[LIM_W-1:CLIM_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.ien  <= 1'b0;
            s_q.drst <= 1'b1;
            s_q.clim <= CLIM_W'(DEF_CLIM);
            s_q.tlim <= TIME_W'(DEF_TIME);
        end else begin
            s_q <= s_d;
        end
    end

    assign ien  = s_q.ien;
    assign drst = s_q.drst;
    assign clim = s_q.clim;
    assign tlim = s_q.tlim;

    AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_we && clr_we && wdata[IEN_BIT]) |=> !ien); // R9

endmodule

// File: rtl/rxc_window.sv
module rxc_window #(
    parameter int CNT_W  = 7,
    parameter int CLIM_W = 8,
    parameter int TIME_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              msg_stb,
    input  logic              lnk_stb,
    input  logic              tick,
    input  logic              drst,
    input  logic              take,
    input  logic [CLIM_W-1:0] clim,
    input  logic [TIME_W-1:0] tlim,
    output logic [CNT_W-1:0]  cnt,
    output logic              lnk,
    output logic              hit
);
    localparam logic [CNT_W-1:0]  CNT_MAX = '1;
    localparam logic [TIME_W-1:0] TMR_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic              lnk;
        logic [TIME_W-1:0] tmr;
    } win_t;

    win_t s_d, s_q, base;
    logic act_q, base_act, cnt_hit, tim_hit;

    always_comb begin
        act_q    = (s_q.cnt != '0) || s_q.lnk;
        cnt_hit  = (s_q.cnt != '0) && (32'(s_q.cnt) >= 32'(clim));
        tim_hit  = act_q && (32'(s_q.tmr) >= 32'(tlim));
        base     = take ? '0 : s_q;
        base_act = (base.cnt != '0) || base.lnk;
        s_d.cnt  = (msg_stb && base.cnt != CNT_MAX) ? base.cnt + 1'b1 : base.cnt;
        s_d.lnk  = base.lnk | lnk_stb;
        if (base_act)
            s_d.tmr = (tick && base.tmr != TMR_MAX) ? base.tmr + 1'b1 : base.tmr;
        else
            s_d.tmr = '0;
        if (drst) s_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt = s_q.cnt;
    assign lnk = s_q.lnk;
    assign hit = cnt_hit || tim_hit;

    AST_CNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.cnt == CNT_MAX && !drst && !take) |=> (s_q.cnt == CNT_MAX)); // R11
    AST_DRST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        drst |=> (s_q.cnt == '0 && !s_q.lnk && s_q.tmr == '0)); // R10
    AST_TMR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!act_q && !msg_stb && !lnk_stb) |=> (s_q.tmr == '0)); // R4

endmodule

// File: rtl/rxc_irq_coalescer.sv
module rxc_irq_coalescer
    import rxc_pkg::*;
#(
    parameter int TAG_W    = 4,
    parameter int CNT_W    = 7,
    parameter int CLIM_W   = 8,
    parameter int TIME_W   = 8,
    parameter int DEF_CLIM = 16,
    parameter int DEF_TIME = 10,
    localparam int LIM_W   = CLIM_W + TIME_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              msg_stb,
    input  logic              lnk_stb,
    input  logic              tick,
    input  logic              ctl_set_we,
    input  logic              ctl_clr_we,
    input  logic [CTL_W-1:0]  ctl_wdata,
    input  logic              lim_we,
    input  logic [LIM_W-1:0]  lim_wdata,
    input  logic              ack_we,
    input  logic [TAG_W-1:0]  ack_tag,
    output logic [STAT_W-1:0] stat_word,
    output logic              stat_wr,
    output logic              irq
);
    typedef struct packed {
        logic [TAG_W-1:0]  tag;
        logic              armed;
        logic              irq;
        logic              wr;
        logic [STAT_W-1:0] stat;
    } top_t;

    top_t s_d, s_q;

    logic              ien, drst, hit, fire, lnk;
    logic [CLIM_W-1:0] clim;
    logic [TIME_W-1:0] tlim;
    logic [CNT_W-1:0]  cnt;

    rxc_cfg #(
        .CLIM_W(CLIM_W), .TIME_W(TIME_W),
        .DEF_CLIM(DEF_CLIM), .DEF_TIME(DEF_TIME)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .set_we(ctl_set_we), .clr_we(ctl_clr_we), .wdata(ctl_wdata),
        .lim_we(lim_we), .lim_wdata(lim_wdata),
        .ien(ien), .drst(drst), .clim(clim), .tlim(tlim)
    );

    rxc_window #(
        .CNT_W(CNT_W), .CLIM_W(CLIM_W), .TIME_W(TIME_W)
    ) u_win (
        .clk(clk), .rst_n(rst_n),
        .msg_stb(msg_stb), .lnk_stb(lnk_stb), .tick(tick),
        .drst(drst), .take(fire), .clim(clim), .tlim(tlim),
        .cnt(cnt), .lnk(lnk), .hit(hit)
    );

    assign fire = s_q.armed && ien && !drst && hit;

    always_comb begin
        s_d    = s_q;
        s_d.wr = 1'b0;
        if (fire) begin
            s_d.stat = '0;
            s_d.stat[TAG_LSB +: TAG_W] = s_q.tag;
            s_d.stat[CNT_LSB +: CNT_W] = cnt;
            s_d.stat[LNK_BIT]          = lnk;
            s_d.wr    = 1'b1;
            s_d.irq   = 1'b1;
            s_d.armed = 1'b0;
        end
        if (ack_we) begin
            s_d.tag   = ack_tag;
            s_d.armed = 1'b1;
            s_d.irq   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign stat_word = s_q.stat;
    assign stat_wr   = s_q.wr;
    assign irq       = s_q.irq;

    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.irq && !ack_we) |=> (s_q.irq && $stable(s_q.stat))); // R6
    AST_ACK_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        ack_we |=> (s_q.tag == $past(ack_tag) && !s_q.irq && s_q.armed)); // R7
    AST_NO_FIRE_DRST: assert property (@(posedge clk) disable iff (!rst_n)
        drst |=> !s_q.wr); // R10
    AST_WR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.wr |=> !s_q.wr); // R3
    AST_NO_FIRE_IEN: assert property (@(posedge clk) disable iff (!rst_n)
        !ien |=> !s_q.wr); // R12

endmodule

// File: tb/sim_rxc_irq_coalescer.sv
module sim_rxc_irq_coalescer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        msg_stb = 0, lnk_stb = 0, tick = 0;
    logic        ctl_set_we = 0, ctl_clr_we = 0, lim_we = 0, ack_we = 0;
    logic [31:0] ctl_wdata = '0;
    logic [15:0] lim_wdata = '0;
    logic [3:0]  ack_tag = '0;
    logic [31:0] stat_word;
    logic        stat_wr, irq;

    int n_cmp = 0, n_bad = 0, wr_seen = 0;
    string cur_req = "R1";
    bit done = 0;

    always #2 clk = ~clk; // 250 MHz

    rxc_irq_coalescer u0 (
        .clk(clk), .rst_n(rst_n), .msg_stb(msg_stb), .lnk_stb(lnk_stb),
        .tick(tick), .ctl_set_we(ctl_set_we), .ctl_clr_we(ctl_clr_we),
        .ctl_wdata(ctl_wdata), .lim_we(lim_we), .lim_wdata(lim_wdata),
        .ack_we(ack_we), .ack_tag(ack_tag), .stat_word(stat_word),
        .stat_wr(stat_wr), .irq(irq)
    );

    // ---------------- reference model ----------------
    logic       m_ien, m_drst, m_lnk, m_armed, m_irq, m_wr;
    logic [7:0] m_clim, m_tlim, m_tmr;
    logic [6:0] m_cnt;
    logic [3:0] m_tag;
    logic [31:0] m_stat;

    function automatic logic [31:0] word(input logic [3:0] t, input logic [6:0] c, input logic l);
        word = {15'd0, l, 5'd0, c, t};
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ien = 0; m_drst = 1; m_clim = 16; m_tlim = 10;
            m_cnt = 0; m_lnk = 0; m_tmr = 0; m_tag = 0;
            m_armed = 0; m_irq = 0; m_wr = 0; m_stat = 0;
        end else begin
            logic act, hit, fire, bact;
            logic [6:0] bc; logic bl; logic [7:0] bt;
            act  = (m_cnt != 0) || m_lnk;
            hit  = ((m_cnt != 0) && ({1'b0, m_cnt} >= m_clim)) || (act && m_tmr >= m_tlim);
            fire = m_armed && m_ien && !m_drst && hit;
            bc = fire ? 7'd0 : m_cnt; bl = fire ? 1'b0 : m_lnk; bt = fire ? 8'd0 : m_tmr;
            bact = (bc != 0) || bl;
            m_wr = fire;
            if (fire) begin
                m_stat = word(m_tag, m_cnt, m_lnk); m_irq = 1; m_armed = 0;
            end
            if (ack_we) begin m_tag = ack_tag; m_armed = 1; m_irq = 0; end
            if (m_drst) begin
                m_cnt = 0; m_lnk = 0; m_tmr = 0;
            end else begin
                m_cnt = (msg_stb && bc != 7'h7f) ? bc + 1 : bc;
                m_lnk = bl | lnk_stb;
                m_tmr = bact ? ((tick && bt != 8'hff) ? bt + 1 : bt) : 8'd0;
            end
            if (ctl_set_we) begin
                if (ctl_wdata[18]) m_ien = 1;
                if (ctl_wdata[17]) m_drst = 1;
            end
            if (ctl_clr_we) begin
                if (ctl_wdata[18]) m_ien = 0;
                if (ctl_wdata[17]) m_drst = 0;
            end
            if (lim_we) begin m_clim = lim_wdata[7:0]; m_tlim = lim_wdata[15:8]; end
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            n_cmp++;
            if (stat_wr) wr_seen++;
            if (irq !== m_irq || stat_wr !== m_wr || stat_word !== m_stat) begin
                n_bad++;
                $display("FAIL %s cycle: irq/wr/stat actual %b/%b/%h expected %b/%b/%h",
                         cur_req, irq, stat_wr, stat_word, m_irq, m_wr, m_stat);
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input logic m, input logic l, input logic t);
        msg_stb = m; lnk_stb = l; tick = t;
        @(negedge clk);
        msg_stb = 0; lnk_stb = 0; tick = 0;
    endtask

    task automatic msgs(input int n);
        for (int i = 0; i < n; i++) step(1, 0, 0);
    endtask

    task automatic ack(input logic [3:0] t);
        ack_we = 1; ack_tag = t;
        @(negedge clk);
        ack_we = 0;
    endtask

    task automatic ctl(input logic s, input logic c, input logic [31:0] d);
        ctl_set_we = s; ctl_clr_we = c; ctl_wdata = d;
        @(negedge clk);
        ctl_set_we = 0; ctl_clr_we = 0;
    endtask

    task automatic lim(input logic [15:0] d);
        lim_we = 1; lim_wdata = d;
        @(negedge clk);
        lim_we = 0;
    endtask

    task automatic expect_stat(input string req, input logic [31:0] exp, input logic tk);
        bit got = 0;
        for (int i = 0; i < 80 && !got; i++) begin
            if (stat_wr) got = 1;
            else step(0, 0, tk);
        end
        if (!got) check(req, 32'hdead_dead, exp);
        else      check(req, stat_word, exp);
    endtask

    initial begin
        #(4 * 190000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int w0;
        void'($urandom(32'h5eed_0042));
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        cur_req = "R1";
        check("R1 stat", stat_word, 32'h0);
        check("R1 irq/wr", {30'd0, irq, stat_wr}, 32'h0);

        // R9: enable on, DMA reset off; R7: nothing before first ack
        cur_req = "R9";
        ctl(1, 0, 32'h0004_0000);
        ctl(0, 1, 32'h0002_0000);
        cur_req = "R7";
        w0 = wr_seen;
        msgs(20);
        repeat (20) step(0, 0, 1);
        check("R7 no fire before ack", wr_seen, w0);
        ack(4'd1);
        expect_stat("R7 first window", 32'h0000_0141, 0);

        // R3: fire exactly at count 16 (default limit), R2 layout
        cur_req = "R3";
        ack(4'd2);
        w0 = wr_seen;
        msgs(15);
        step(0, 0, 0);
        check("R3 below limit", wr_seen, w0);
        msgs(1);
        expect_stat("R3/R2 count limit", 32'h0000_0102, 0);

        // R6: frozen window, arrivals carried over
        cur_req = "R6";
        msgs(3);
        step(0, 0, 0);
        check("R6 irq held", {31'd0, irq}, 32'h1);
        check("R6 stat frozen", stat_word, 32'h0000_0102);
        ack(4'd3);
        check("R6 irq cleared by ack", {31'd0, irq}, 32'h0);

        // R4: time limit (default 10 ticks)
        cur_req = "R4";
        expect_stat("R4 time limit", 32'h0000_0033, 1);

        // R5: link only
        cur_req = "R5";
        ack(4'd4);
        step(0, 1, 0);
        expect_stat("R5 link only", 32'h0001_0004, 1);

        // R8: limit register fields
        cur_req = "R8";
        lim(16'h0204);
        ack(4'd5);
        msgs(4);
        expect_stat("R8 count limit 4", 32'h0000_0045, 0);

        // R10: DMA reset
        cur_req = "R10";
        ack(4'd6);
        ctl(1, 0, 32'h0002_0000);
        w0 = wr_seen;
        for (int i = 0; i < 10; i++) step(1, 1, 1);
        ctl(0, 1, 32'h0002_0000);
        repeat (5) step(0, 0, 1);
        check("R10 nothing fired", wr_seen, w0);
        check("R10 irq low", {31'd0, irq}, 32'h0);
        msgs(4);
        expect_stat("R10 window restarted", 32'h0000_0046, 0);

        // R9 clear wins, R12 disabled accumulation
        cur_req = "R12";
        ctl(1, 1, 32'h0004_0000);
        ack(4'd7);
        w0 = wr_seen;
        msgs(6);
        repeat (4) step(0, 0, 1);
        check("R9/R12 no fire while disabled", wr_seen, w0);
        ctl(1, 0, 32'h0004_0000);
        expect_stat("R12 fire after enable", 32'h0000_0067, 0);

        // R11: saturation
        cur_req = "R11";
        lim(16'hFFFF);
        ack(4'd8);
        msgs(130);
        lim(16'h00FF);
        expect_stat("R11 saturated count", 32'h0000_07F8, 0);

        // random traffic with a host that acks with tag+1
        cur_req = "R6";
        lim(16'h0308);
        ack(4'd9);
        begin
            bit waiting = 0;
            int dly = 0;
            for (int c = 0; c < 4000; c++) begin
                if (irq && !waiting) begin waiting = 1; dly = $urandom % 15; end
                if (waiting && dly == 0) begin
                    ack_we = 1; ack_tag = stat_word[3:0] + 4'd1; waiting = 0;
                end else if (waiting) dly--;
                step(($urandom % 10) < 3, ($urandom % 40) == 0, ($urandom % 8) == 0);
                ack_we = 0;
            end
        end
        repeat (3) step(0, 0, 0);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule